// File: doc/BRIEF.md
# Frame Timer with Blanking Access Windows

This block produces the frame timing of a tile-based video controller, measured in CPU clock cycles. A scanline counter and a line counter walk through every frame; when the last active line ends and the bottom border begins, the block raises an interrupt request toward the CPU. That request comes back once per frame at a fixed rate, whether the picture is shown or not.

The same timing qualifies CPU access to the controller's own registers and to its graphics memory. While the picture is shown, both resources are closed during active lines. They open only after the CPU has acknowledged the blanking interrupt. Register access then lasts a shorter time than graphics access. A frame in which the picture is blanked leaves both resources open for the whole frame. The picture stays on only if the CPU writes, with any data, to a strobe address during each frame while register access is open. That write switches the display on for the next frame. A frame with no such write is blanked. Gated writes are dropped and gated reads return all ones. Open accesses pass the memory's read data through and raise the write enable of the region that was hit.

Top module: `vblank_frame_timer`

## Requirements
- R1: After reset the frame starts at line 0, cycle 0. The interrupt request and the display-active flag are low. Because the first frame is blanked, both access grants are high.
- R2: The interrupt request rises on the first cycle of the first blanking line, which is cycle ACTIVE_LINES*CYCLES_PER_LINE of the frame. It rises again one frame of LINES_PER_FRAME*CYCLES_PER_LINE cycles later, whether the display is enabled or not.
- R3: Once raised, the interrupt request stays high until an acknowledge pulse is sampled. It is low on the cycle after that acknowledge.
- R4: A write of any data to address STROBE_ADDR (default 0x20) that is accepted while register access is granted enables the display for the next frame. The display-active flag is then high on that frame's active lines and low on its blanking lines. A frame that follows a frame with no accepted strobe write is blanked.
- R5: In a frame with the display enabled, both grants are low during active lines and during blanking until an acknowledge. In that state, writes to either region raise no write enable, and a strobe write does not arm the display.
- R6: An acknowledge sampled while the interrupt request is high during blanking opens the register grant on the next cycle, for exactly REG_WINDOW cycles.
- R7: The same acknowledge opens the graphics grant on the next cycle, for exactly GFX_WINDOW cycles. GFX_WINDOW is at least REG_WINDOW, so register access never outlasts graphics access.
- R8: In a frame with the display blanked, both grants stay high for the whole frame. Writes to the register region raise regWe, and writes to the graphics region raise gfxWe.
- R9: The register region is [REG_BASE, REG_BASE+REG_SPAN), default 0x0000..0x003F. The graphics region is [GFX_BASE, GFX_BASE+GFX_SPAN), default 0x3800..0x3FFF. A read of a region that is granted returns memRdata. A read of a region that is not granted, or of an address outside both regions, returns 0xFFFF.
- R10: An acknowledge that arrives while the interrupt request is low is ignored: no window opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| intAck | input | 1 | Interrupt acknowledge pulse from the CPU |
| cpuValid | input | 1 | CPU bus access in this cycle |
| cpuWe | input | 1 | Access is a write |
| cpuAddr | input | ADDR_W | CPU address |
| memRdata | input | DATA_W | Read data from the selected memory or register file |
| irq | output | 1 | Blanking interrupt request |
| displayActive | output | 1 | Picture shown on this line |
| regGrant | output | 1 | Controller registers open to the CPU |
| gfxGrant | output | 1 | Graphics memory open to the CPU |
| regWe | output | 1 | Qualified write enable for the register region |
| gfxWe | output | 1 | Qualified write enable for the graphics memory |
| cpuRdata | output | DATA_W | Qualified read data returned to the CPU |

## Verification
The hardest state to reach is a display-enabled frame in its blanking period with the acknowledge already taken. Getting there needs a strobe write in the frame before, and then an acknowledge timed inside the pending interrupt. The stimulus first uses the unlimited access of the blanked first frame to write the strobe. It then acknowledges at a known cycle of the next frame and probes both grant edges cycle by cycle. A stray acknowledge during active lines, a strobe dropped during active lines, and a frame left without a strobe show that each of these has no effect and that the display falls back to blanked.

// File: rtl/vft_pkg.sv
package vft_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic frameWrap;   // last cycle of the frame
    logic winStart;    // acknowledge accepted during blanking
    logic frameEn;     // display enabled in the current frame
    logic inActive;    // current line is an active line
  } vft_ctl_t;
endpackage

// File: rtl/vft_ctrl.sv
module vft_ctrl
  import vft_pkg::*;
#(
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned ACTIVE_LINES    = 192,
  parameter int unsigned CYCLES_PER_LINE = 57
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     intAck,
  input  logic     strobeHit,
  output logic     irq,
  output logic     displayActive,
  output vft_ctl_t ctl
);
  localparam int unsigned CW = (CYCLES_PER_LINE > 1) ? $clog2(CYCLES_PER_LINE) : 1;
  localparam int unsigned LW = (LINES_PER_FRAME > 1) ? $clog2(LINES_PER_FRAME) : 1;
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYCLES_PER_LINE - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES_PER_FRAME - 1);
  localparam logic [LW-1:0] ACT_LAST  = LW'(ACTIVE_LINES - 1);
  localparam logic [LW-1:0] ACT_END   = LW'(ACTIVE_LINES);

  logic [CW-1:0] cycCnt;
  logic [LW-1:0] lineCnt;
  logic          frameEn;
  logic          armNext;
  logic          lineEnd, frameWrap, enterBlank, inActive;

  always_comb begin
    lineEnd    = (cycCnt == CYC_LAST);
    frameWrap  = lineEnd && (lineCnt == LINE_LAST);
    enterBlank = lineEnd && (lineCnt == ACT_LAST);
    inActive   = (lineCnt < ACT_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt  <= '0;
      lineCnt <= '0;
    end else if (lineEnd) begin
      cycCnt  <= '0;
      lineCnt <= frameWrap ? '0 : lineCnt + LW'(1);
    end else begin
      cycCnt <= cycCnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           irq <= 1'b0;
    else if (enterBlank) irq <= 1'b1;
    else if (intAck)     irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameEn <= 1'b0;
      armNext <= 1'b0;
    end else if (frameWrap) begin
      frameEn <= armNext || strobeHit;
      armNext <= 1'b0;
    end else if (strobeHit) begin
      armNext <= 1'b1;
    end
  end

  always_comb begin
    displayActive = frameEn && inActive;
    ctl.frameWrap = frameWrap;
    ctl.winStart  = intAck && irq && !inActive;
    ctl.frameEn   = frameEn;
    ctl.inActive  = inActive;
  end

  AST_IRQ_AT_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (lineCnt == ACT_END && cycCnt == '0)); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !intAck) |=> irq); // R3
  AST_IRQ_FALL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(intAck)); // R3
  AST_DISP_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameEn) |-> ($past(armNext) || $past(strobeHit))); // R4
endmodule

// File: rtl/vft_dp.sv
module vft_dp
  import vft_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned REG_WINDOW  = 2000,
  parameter int unsigned GFX_WINDOW  = 3780,
  parameter int unsigned STROBE_ADDR = 'h20,
  parameter int unsigned REG_BASE    = 'h0000,
  parameter int unsigned REG_SPAN    = 'h0040,
  parameter int unsigned GFX_BASE    = 'h3800,
  parameter int unsigned GFX_SPAN    = 'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  vft_ctl_t          ctl,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              regGrant,
  output logic              gfxGrant,
  output logic              regWe,
  output logic              gfxWe,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              strobeHit
);
  localparam int unsigned WW = $clog2(GFX_WINDOW + 1);
  localparam logic [WW-1:0] REG_LIM = WW'(REG_WINDOW);
  localparam logic [WW-1:0] GFX_LIM = WW'(GFX_WINDOW);
  localparam logic [31:0] REG_END = 32'(REG_BASE + REG_SPAN);
  localparam logic [31:0] GFX_END = 32'(GFX_BASE + GFX_SPAN);
  localparam logic [DATA_W-1:0] GATED_PATTERN = '1;

  logic [WW-1:0] winCnt;
  logic          winActive;
  logic          regOpen, gfxOpen;
  logic [31:0]   addrExt;
  logic          inReg, inGfx, passRead;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.frameWrap) begin
      winActive <= 1'b0;
      winCnt    <= '0;
    end else if (ctl.winStart) begin
      winActive <= 1'b1;
      winCnt    <= '0;
    end else if (winActive && winCnt != GFX_LIM) begin
      winCnt <= winCnt + WW'(1);
    end
  end

  always_comb begin
    regOpen  = winActive && (winCnt < REG_LIM);
    gfxOpen  = winActive && (winCnt < GFX_LIM);
    regGrant = !ctl.frameEn || regOpen;
    gfxGrant = !ctl.frameEn || gfxOpen;

    addrExt  = 32'(cpuAddr);
    inReg    = (addrExt >= 32'(REG_BASE)) && (addrExt < REG_END);
    inGfx    = (addrExt >= 32'(GFX_BASE)) && (addrExt < GFX_END);

    regWe     = cpuValid && cpuWe && inReg && regGrant;
    gfxWe     = cpuValid && cpuWe && inGfx && gfxGrant;
    strobeHit = regWe && (addrExt == 32'(STROBE_ADDR));
    passRead  = (inReg && regGrant) || (inGfx && gfxGrant);
    cpuRdata  = passRead ? memRdata : GATED_PATTERN;
  end

  AST_CLOSED_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frameEn && ctl.inActive) |-> !(regGrant || gfxGrant)); // R5
  AST_REG_INSIDE_GFX: assert property (@(posedge clk) disable iff (!rstN)
    regGrant |-> gfxGrant); // R7
  AST_WIN_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frameEn && $rose(gfxGrant)) |-> $past(ctl.winStart)); // R6
  AST_REG_CLOSE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frameEn && $fell(regGrant) && !ctl.frameWrap) |=> !regGrant); // R6
endmodule

// File: rtl/vblank_frame_timer.sv
module vblank_frame_timer
  import vft_pkg::*;
#(
  parameter int unsigned LINES_PER_FRAME = 262,
  parameter int unsigned ACTIVE_LINES    = 192,
  parameter int unsigned CYCLES_PER_LINE = 57,
  parameter int unsigned REG_WINDOW      = 2000,
  parameter int unsigned GFX_WINDOW      = 3780,
  parameter int unsigned ADDR_W          = 16,
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned STROBE_ADDR     = 'h20,
  parameter int unsigned REG_BASE        = 'h0000,
  parameter int unsigned REG_SPAN        = 'h0040,
  parameter int unsigned GFX_BASE        = 'h3800,
  parameter int unsigned GFX_SPAN        = 'h0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intAck,
  input  logic              cpuValid,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq,
  output logic              displayActive,
  output logic              regGrant,
  output logic              gfxGrant,
  output logic              regWe,
  output logic              gfxWe,
  output logic [DATA_W-1:0] cpuRdata
);
  vft_ctl_t ctl;
  logic     strobeHit;

  vft_ctrl #(
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .ACTIVE_LINES   (ACTIVE_LINES),
    .CYCLES_PER_LINE(CYCLES_PER_LINE)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .intAck       (intAck),
    .strobeHit    (strobeHit),
    .irq          (irq),
    .displayActive(displayActive),
    .ctl          (ctl)
  );

  vft_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .REG_WINDOW (REG_WINDOW),
    .GFX_WINDOW (GFX_WINDOW),
    .STROBE_ADDR(STROBE_ADDR),
    .REG_BASE   (REG_BASE),
    .REG_SPAN   (REG_SPAN),
    .GFX_BASE   (GFX_BASE),
    .GFX_SPAN   (GFX_SPAN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .cpuValid (cpuValid),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .memRdata (memRdata),
    .regGrant (regGrant),
    .gfxGrant (gfxGrant),
    .regWe    (regWe),
    .gfxWe    (gfxWe),
    .cpuRdata (cpuRdata),
    .strobeHit(strobeHit)
  );
endmodule

// File: tb/vblank_frame_timer_tb.sv
module vblank_frame_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 10, ACT = 6, CPL = 8, RWIN = 10, GWIN = 20;
  localparam int FRAME = LINES * CPL;
  localparam logic [15:0] MEMV = 16'h5A3C;

  logic clk = 1'b0, rstN = 1'b0, intAck = 1'b0, cpuValid = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0, memRdata = MEMV;
  logic irq, displayActive, regGrant, gfxGrant, regWe, gfxWe;
  logic [15:0] cpuRdata;

  int checks = 0, failures = 0, pos = 0, frm = 0;
  bit done = 0;

  typedef struct { string req; logic [15:0] rd; logic rw; logic gw; } exp_t;
  exp_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vblank_frame_timer #(
    .LINES_PER_FRAME(LINES), .ACTIVE_LINES(ACT), .CYCLES_PER_LINE(CPL),
    .REG_WINDOW(RWIN), .GFX_WINDOW(GWIN)
  ) u_dut (
    .clk(clk), .rstN(rstN), .intAck(intAck), .cpuValid(cpuValid), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .memRdata(memRdata), .irq(irq), .displayActive(displayActive),
    .regGrant(regGrant), .gfxGrant(gfxGrant), .regWe(regWe), .gfxWe(gfxWe),
    .cpuRdata(cpuRdata)
  );

  // bench frame position model
  always @(posedge clk) begin
    if (!rstN) begin pos <= 0; frm <= 0; end
    else if (pos == FRAME - 1) begin pos <= 0; frm <= frm + 1; end
    else pos <= pos + 1;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s f%0d p%0d actual=%h expected=%h", req, frm, pos, act, exp);
    end
  endtask

  task automatic waitPos(int f, int p);
    while (!(frm == f && pos == p)) @(negedge clk);
  endtask

  // driver: one access, expected result pushed to the scoreboard
  task automatic access(string req, logic [15:0] a, logic w,
                        logic [15:0] rd, logic rw, logic gw);
    exp_t e;
    cpuValid = 1'b1; cpuWe = w; cpuAddr = a;
    e.req = req; e.rd = rd; e.rw = rw; e.gw = gw;
    sbQ.push_back(e);
    @(negedge clk);
    cpuValid = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  // monitor: compares qualified bus outputs to the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sbQ.size() > 0) begin
        exp_t e;
        e = sbQ.pop_front();
        chk(e.req, cpuRdata, e.rd);
        chk(e.req, {15'b0, regWe}, {15'b0, e.rw});
        chk(e.req, {15'b0, gfxWe}, {15'b0, e.gw});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", {12'b0, irq, displayActive, regGrant, gfxGrant}, 16'b0011);
    // frame 0: display blanked, unlimited access (R8)
    waitPos(0, 10); access("R8", 16'h0005, 1'b1, MEMV, 1'b1, 1'b0);
    waitPos(0, 12); access("R8", 16'h3810, 1'b1, MEMV, 1'b0, 1'b1);
    waitPos(0, 47); chk("R2", {15'b0, irq}, 16'd0);
    waitPos(0, 48); chk("R2", {15'b0, irq}, 16'd1);
    waitPos(0, 60); access("R4", 16'h0020, 1'b1, MEMV, 1'b1, 1'b0);
    waitPos(0, 70); chk("R3", {15'b0, irq}, 16'd1);
    ack();
    chk("R3", {15'b0, irq}, 16'd0);
    // frame 1: enabled by strobe
    waitPos(1, 2);
    chk("R4", {15'b0, displayActive}, 16'd1);
    chk("R5", {14'b0, regGrant, gfxGrant}, 16'b00);
    access("R9", 16'h0005, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    access("R5", 16'h3900, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    waitPos(1, 30); ack();
    waitPos(1, 40); chk("R10", {14'b0, regGrant, gfxGrant}, 16'b00);
    waitPos(1, 47); chk("R4", {15'b0, displayActive}, 16'd1);
    waitPos(1, 48);
    chk("R4", {15'b0, displayActive}, 16'd0);
    chk("R2", {15'b0, irq}, 16'd1);
    waitPos(1, 50); chk("R5", {14'b0, regGrant, gfxGrant}, 16'b00);
    waitPos(1, 52); chk("R6", {15'b0, regGrant}, 16'd0);
    ack();
    chk("R6", {14'b0, regGrant, gfxGrant}, 16'b11);
    chk("R3", {15'b0, irq}, 16'd0);
    waitPos(1, 55); access("R4", 16'h0020, 1'b1, MEMV, 1'b1, 1'b0);
    access("R9", 16'h0010, 1'b0, MEMV, 1'b0, 1'b0);
    waitPos(1, 62); chk("R6", {15'b0, regGrant}, 16'd1);
    waitPos(1, 63);
    chk("R6", {15'b0, regGrant}, 16'd0);
    chk("R7", {15'b0, gfxGrant}, 16'd1);
    waitPos(1, 65); access("R9", 16'h3A00, 1'b0, MEMV, 1'b0, 1'b0);
    access("R9", 16'h0007, 1'b0, 16'hFFFF, 1'b0, 1'b0);
    access("R9", 16'h1000, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    waitPos(1, 72); chk("R7", {15'b0, gfxGrant}, 16'd1);
    waitPos(1, 73); chk("R7", {15'b0, gfxGrant}, 16'd0);
    // frame 2: enabled; strobe during active lines is dropped
    waitPos(2, 5); access("R5", 16'h0020, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    waitPos(2, 10); chk("R4", {15'b0, displayActive}, 16'd1);
    waitPos(2, 48); chk("R2", {15'b0, irq}, 16'd1);
    waitPos(2, 50); ack();
    // frame 3: no accepted strobe -> blanked, unlimited access
    waitPos(3, 10);
    chk("R4", {15'b0, displayActive}, 16'd0);
    chk("R8", {14'b0, regGrant, gfxGrant}, 16'b11);
    waitPos(3, 47); chk("R2", {15'b0, irq}, 16'd0);
    waitPos(3, 48); chk("R2", {15'b0, irq}, 16'd1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule